// File: doc/BRIEF.md
# Synchronous Burst Write Slave

This block is the write side of a synchronous host-bus slave with a separate address bus and a 32-bit data bus. A host opens a burst by pulsing the active-low strobe for one clock while the active-low select is low, the direction input says "write" and the start address sits on the address bus. The block latches that address and the memory/register space flag. It lowers its active-low ready output, then takes one data beat on every following clock edge in which ready is low. After each beat it steps the address by one beat location.

Each beat is split into two 16-bit halves with their own enable bits. A half whose enable is 0 is not written. A burst aimed at register space only accepts beats with both halves enabled. Any other enable value raises a one-cycle error pulse, and that beat is not written. The active-low last input marks the final beat. Raising select before the final beat aborts the burst. A queue-full input from the command path holds the burst through an active-low stop output. While stop is low the block takes no data. The write port feeds a plain synchronous memory or register file.

Top module: `burst_wr_slave`

## Requirements
- R1: A clock edge that sees `strb_n`=0, `sel_n`=0 and `rd_wr_n`=0 while idle starts a burst at the address on `addr`. With `rd_wr_n`=1 the block stays idle: `rdy_n` stays high and nothing is written.
- R2: `rdy_n` goes low in the cycle right after the start edge, one clock before the edge that captures the first beat.
- R3: Each edge with `rdy_n` low and `sel_n` low captures one beat at the current address. The address then steps by 1 (word addressing). The write port (`mwr_en`, `mwr_addr`, `mwr_data`, `mwr_reg`) shows the beat in the cycle after the capture edge.
- R4: `wen[0]` enables data bits 15:0 and `wen[1]` enables bits 31:16. Matching bits of `mwr_en` follow them. A beat with `wen`=00 in memory space writes nothing, but it still uses an address.
- R5: A beat captured with `last_n`=0 is the final one. `rdy_n` is high in the next cycle and the block is idle.
- R6: When `mem_reg_n`=0 at the start edge (register space), a beat with `wen` other than 11 gives `err`=1 for one cycle after its capture edge, with `mwr_en`=00. The burst goes on.
- R7: `stop_n` is low in the cycle after an edge that samples `queue_full`=1, and high in the cycle after an edge that samples it 0.
- R8: While `stop_n` is low, `rdy_n` is high and no beat is captured. Capture resumes once `stop_n` is high again.
- R9: If `sel_n` is high at an edge during a burst, the block returns to idle with `rdy_n` high, and no further beats are written.
- R10: After reset `rdy_n`=1, `stop_n`=1, `mwr_en`=00 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| strb_n | input | 1 | Active-low burst start strobe |
| rd_wr_n | input | 1 | Direction: 0 write, 1 read |
| mem_reg_n | input | 1 | Space: 1 memory, 0 register |
| addr | input | 16 | Start address |
| data | input | 32 | Write data beat |
| wen | input | 2 | Half enables, bit i for half i |
| last_n | input | 1 | Active-low final-beat marker |
| queue_full | input | 1 | Command queue full |
| rdy_n | output | 1 | Active-low data ready |
| stop_n | output | 1 | Active-low backpressure stop |
| mwr_en | output | 2 | Write port half enables |
| mwr_addr | output | 16 | Write port address |
| mwr_data | output | 32 | Write port data |
| mwr_reg | output | 1 | Write port targets register space |
| err | output | 1 | Register-space enable error pulse |

## Verification
Ready is due in the cycle after the start edge. Every write or error pulse is due in the cycle after the edge that captured its beat. Stop follows queue-full one edge later, and ready is high again one cycle after the last or aborting edge. The driver changes inputs and samples on the falling edge. It pushes the expected write into the scoreboard queue at the same falling edge where it sees ready low and presents the beat. The monitor pops that item at the next falling edge, after the capture register has loaded, so every comparison lands exactly one cycle after its stimulus.

// File: rtl/bwh_pkg.sv
package bwh_pkg;

   typedef enum logic [0:0] {
      BWH_IDLE  = 1'b0,
      BWH_BURST = 1'b1
   } bwh_state_t;

endpackage

// File: rtl/bwh_ctrl.sv
module bwh_ctrl
   import bwh_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic strb_n,
   input  logic rd_wr_n,
   input  logic last_n,
   input  logic queue_full,
   output logic start,
   output logic capture,
   output logic full_q,
   output logic ready
);

   bwh_state_t state_q, state_d;

   // queue-full is registered so stop and ready both come from flops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) full_q <= 1'b0;
      else        full_q <= queue_full;
   end

   assign start   = (state_q == BWH_IDLE) && !sel_n && !strb_n && !rd_wr_n;
   assign ready   = (state_q == BWH_BURST) && !full_q;
   assign capture = ready && !sel_n;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         BWH_IDLE:  if (start) state_d = BWH_BURST;
         BWH_BURST: begin
            if (sel_n)                  state_d = BWH_IDLE;
            else if (capture && !last_n) state_d = BWH_IDLE;
         end
         default:   state_d = BWH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= BWH_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/bwh_addr_gen.sv
module bwh_addr_gen #(
   parameter int ADDR_W     = 16,
   parameter int BEAT_BYTES = 4,
   parameter bit BYTE_ADDR  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] cur_addr
);

   logic [ADDR_W-1:0] incr;

   generate
      if (BYTE_ADDR) begin : g_byte_step
         assign incr = ADDR_W'(BEAT_BYTES);
      end else begin : g_word_step
         assign incr = ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cur_addr <= '0;
      else if (load) cur_addr <= start_addr;
      else if (step) cur_addr <= cur_addr + incr;
   end

endmodule

// File: rtl/bwh_lane_gate.sv
module bwh_lane_gate #(
   parameter int LANES      = 2,
   parameter bit REG_STRICT = 1'b1
) (
   input  logic             capture,
   input  logic             is_reg,
   input  logic [LANES-1:0] wen,
   output logic [LANES-1:0] lane_we,
   output logic             bad_reg
);

   logic blocked;

   generate
      if (REG_STRICT) begin : g_strict
         assign blocked = is_reg && !(&wen);
      end else begin : g_loose
         assign blocked = 1'b0;
      end
   endgenerate

   assign bad_reg = capture && blocked;

   for (genvar li = 0; li < LANES; li++) begin : g_lane
      assign lane_we[li] = capture && wen[li] && !blocked;
   end

endmodule

// File: rtl/burst_wr_slave.sv
module burst_wr_slave
   import bwh_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 16,
   parameter bit BYTE_ADDR  = 1'b0,
   parameter bit REG_STRICT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sel_n,
   input  logic                       strb_n,
   input  logic                       rd_wr_n,
   input  logic                       mem_reg_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          data,
   input  logic [DATA_W/LANE_W-1:0]   wen,
   input  logic                       last_n,
   input  logic                       queue_full,
   output logic                       rdy_n,
   output logic                       stop_n,
   output logic [DATA_W/LANE_W-1:0]   mwr_en,
   output logic [ADDR_W-1:0]          mwr_addr,
   output logic [DATA_W-1:0]          mwr_data,
   output logic                       mwr_reg,
   output logic                       err
);

   localparam int LANES      = DATA_W / LANE_W;
   localparam int BEAT_BYTES = DATA_W / 8;

   generate
      if (DATA_W % LANE_W != 0) begin : g_bad_lane
         $error("DATA_W must be a multiple of LANE_W");
      end
      if (LANE_W % 8 != 0) begin : g_bad_byte
         $error("LANE_W must be a whole number of bytes");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   logic             start, capture, full_q, ready;
   logic             space_reg_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [LANES-1:0] lane_we;
   logic             bad_reg;

   bwh_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_n      (sel_n),
      .strb_n     (strb_n),
      .rd_wr_n    (rd_wr_n),
      .last_n     (last_n),
      .queue_full (queue_full),
      .start      (start),
      .capture    (capture),
      .full_q     (full_q),
      .ready      (ready)
   );

   bwh_addr_gen #(
      .ADDR_W     (ADDR_W),
      .BEAT_BYTES (BEAT_BYTES),
      .BYTE_ADDR  (BYTE_ADDR)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .step       (capture),
      .start_addr (addr),
      .cur_addr   (cur_addr)
   );

   // space is fixed for the whole burst at the start edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     space_reg_q <= 1'b0;
      else if (start) space_reg_q <= !mem_reg_n;
   end

   bwh_lane_gate #(
      .LANES      (LANES),
      .REG_STRICT (REG_STRICT)
   ) u_gate (
      .capture (capture),
      .is_reg  (space_reg_q),
      .wen     (wen),
      .lane_we (lane_we),
      .bad_reg (bad_reg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mwr_en   <= '0;
         mwr_addr <= '0;
         mwr_data <= '0;
         mwr_reg  <= 1'b0;
         err      <= 1'b0;
      end else begin
         mwr_en <= lane_we;
         err    <= bad_reg;
         if (capture) begin
            mwr_addr <= cur_addr;
            mwr_data <= data;
            mwr_reg  <= space_reg_q;
         end
      end
   end

   assign rdy_n  = !ready;
   assign stop_n = !full_q;

endmodule

// File: rtl/bwh_chk.sv
module bwh_chk #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel_n,
   input logic             last_n,
   input logic             queue_full,
   input logic             rdy_n,
   input logic             stop_n,
   input logic [LANES-1:0] mwr_en,
   input logic             err
);

   assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      queue_full |=> !stop_n);

   assert_stop_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !queue_full |=> stop_n);

   assert_no_ready_in_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n |-> rdy_n);

   assert_no_write_in_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n |=> (mwr_en == '0 && !err));

   assert_write_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mwr_en != '0) |-> $past(!rdy_n && !sel_n));

   assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && !sel_n && !last_n) |=> rdy_n);

   assert_abort_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && sel_n) |=> (rdy_n && mwr_en == '0));

   assert_err_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (mwr_en == '0));

endmodule

bind burst_wr_slave bwh_chk #(.LANES(DATA_W / LANE_W)) u_bwh_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel_n      (sel_n),
   .last_n     (last_n),
   .queue_full (queue_full),
   .rdy_n      (rdy_n),
   .stop_n     (stop_n),
   .mwr_en     (mwr_en),
   .err        (err)
);

// File: tb/burst_wr_slave_test.sv
`timescale 1ns/1ps
module burst_wr_slave_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1, strb_n = 1'b1, rd_wr_n = 1'b0, mem_reg_n = 1'b1;
   logic [15:0] addr = '0;
   logic [31:0] data = '0;
   logic [1:0]  wen = 2'b11;
   logic        last_n = 1'b1, queue_full = 1'b0;
   logic        rdy_n, stop_n, mwr_reg, err;
   logic [1:0]  mwr_en;
   logic [15:0] mwr_addr;
   logic [31:0] mwr_data;

   always #4 clk = ~clk;

   burst_wr_slave uut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strb_n(strb_n), .rd_wr_n(rd_wr_n),
      .mem_reg_n(mem_reg_n), .addr(addr), .data(data), .wen(wen), .last_n(last_n),
      .queue_full(queue_full), .rdy_n(rdy_n), .stop_n(stop_n), .mwr_en(mwr_en),
      .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_reg(mwr_reg), .err(err)
   );

   typedef struct {
      logic [15:0] a;
      logic [31:0] d;
      logic [1:0]  en;
      logic        rg;
      logic        er;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // monitor: each write or error pulse pops the oldest expected item
   always @(negedge clk) begin
      if (rst_n && !finished && (mwr_en != 2'b00 || err)) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected write", {mwr_en, err}, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.er) begin
               chk(err && mwr_en == 2'b00, "R6", "error pulse", {mwr_en, err}, 1);
            end else begin
               chk(!err, "R6", "no error", err, 0);
               chk(mwr_en == e.en, "R4", "half enables", mwr_en, e.en);
               chk(mwr_addr == e.a, "R3", "address", mwr_addr, e.a);
               chk(mwr_data == e.d, "R3", "data", mwr_data, e.d);
               chk(mwr_reg == e.rg, "R6", "space flag", mwr_reg, e.rg);
            end
         end
      end
   end

   function automatic logic [31:0] beat_data(input logic [15:0] a, input int i);
      return {a ^ 16'hA5C3, 16'(i) * 16'h0101 + 16'h1234};
   endfunction

   // driver: one burst; stall window and abort point are optional (-1 = none)
   task automatic burst(input logic [15:0] a, input int n, input bit rg,
                        input logic [7:0] wseq, input int st_at, input int st_len,
                        input int abort_at);
      int i;
      int c;
      logic [1:0] w;
      exp_t e;
      @(negedge clk);
      sel_n = 1'b0; strb_n = 1'b0; rd_wr_n = 1'b0; mem_reg_n = !rg; addr = a;
      @(negedge clk);
      strb_n = 1'b1; addr = 16'hFFFF;
      chk(rdy_n == 1'b0, "R2", "ready one cycle after start", rdy_n, 0);
      i = 0;
      c = 0;
      while (i < n) begin
         if (st_len > 0 && c == st_at + 1)
            chk(stop_n == 1'b0, "R7", "stop follows queue full", stop_n, 0);
         if (!stop_n)
            chk(rdy_n == 1'b1, "R8", "ready high during stop", rdy_n, 1);
         queue_full = (st_len > 0) && (c >= st_at) && (c < st_at + st_len);
         if (abort_at >= 0 && i == abort_at) begin
            sel_n = 1'b1;
            break;
         end
         if (!rdy_n) begin
            w = wseq[2*(i%4) +: 2];
            wen = w;
            data = beat_data(a, i);
            last_n = (i == n - 1) ? 1'b0 : 1'b1;
            e.a = a + 16'(i); e.d = data; e.en = w; e.rg = rg; e.er = 1'b0;
            if (rg && w != 2'b11) begin
               e.er = 1'b1;
               exp_q.push_back(e);
            end else if (w != 2'b00) begin
               exp_q.push_back(e);
            end
            i++;
         end
         c++;
         @(negedge clk);
      end
      if (abort_at >= 0) begin
         @(negedge clk);
         chk(rdy_n == 1'b1, "R9", "ready high after abort", rdy_n, 1);
      end else begin
         chk(rdy_n == 1'b1, "R5", "ready high after last beat", rdy_n, 1);
      end
      sel_n = 1'b1; last_n = 1'b1; queue_full = 1'b0; wen = 2'b11;
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "all expected writes seen", exp_q.size(), 0);
      chk(stop_n == 1'b1, "R7", "stop high with queue free", stop_n, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R3", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(rdy_n == 1'b1, "R10", "reset ready", rdy_n, 1);
      chk(stop_n == 1'b1, "R10", "reset stop", stop_n, 1);
      chk(mwr_en == 2'b00, "R10", "reset enables", mwr_en, 0);
      chk(err == 1'b0, "R10", "reset error", err, 0);

      // R1 read direction does not start a burst
      sel_n = 1'b0; strb_n = 1'b0; rd_wr_n = 1'b1; addr = 16'h0040;
      @(negedge clk);
      strb_n = 1'b1;
      chk(rdy_n == 1'b1, "R1", "read strobe stays idle", rdy_n, 1);
      repeat (3) @(negedge clk);
      chk(rdy_n == 1'b1, "R1", "still idle", rdy_n, 1);
      sel_n = 1'b1; rd_wr_n = 1'b0;
      repeat (2) @(negedge clk);

      // R1 R3 R5 plain memory burst, all halves
      burst(16'h0100, 5, 1'b0, 8'hFF, -1, 0, -1);
      // R4 mixed half enables including 00
      burst(16'h0200, 8, 1'b0, 8'b00_10_01_11, -1, 0, -1);
      // R7 R8 stall in the middle
      burst(16'h0300, 6, 1'b0, 8'hFF, 2, 3, -1);
      // R6 register space with bad enables
      burst(16'h0010, 4, 1'b1, 8'b10_11_01_11, -1, 0, -1);
      // R9 abort after two beats
      burst(16'h0400, 6, 1'b0, 8'hFF, -1, 0, 2);
      // R5 single beat burst
      burst(16'hFFFF, 1, 1'b0, 8'hFF, -1, 0, -1);
      // R8 stall starting on first data cycle
      burst(16'h0500, 3, 1'b0, 8'hFF, 0, 2, -1);

      summary();
   end

endmodule